// File: doc/BRIEF.md
# Command Register Handoff Unit

This block is the host-side command register set of a memory-card host controller. Software writes a command word, an argument and the transfer parameters over a simple word-addressed register bus. When software sets the start flag in the command word, the block takes a snapshot of the relevant registers and hands it to the card-clock-domain engine. The handover uses a level request that stays high until the engine returns a one-cycle acknowledge.

While a command is pending, the block refuses writes to every register that is handed over and records a lock error. A command word with the clock-update-only flag set sends no command. In that case only the clock divider, clock source and clock enable values are handed over, and no command-done interrupt follows. Two raw interrupt bits are write-1-to-clear. They are masked and combined onto one interrupt line. A registered copy of the card slot field is driven out for DMA request steering.

Top module: `cmd_handoff_top`

Register map (word index on `reg_addr`): 0 command word, 1 argument, 2 timeout, 3 card type, 4 block size, 5 byte count, 6 clock divider, 7 clock source, 8 clock enable, 9 raw interrupts, 10 interrupt mask. Any other index reads as zero. Command word fields: bit 31 start, bit 29 hold-register select, bit 21 clock-update-only, bits 20:16 card slot. Interrupt bits: bit 0 command done, bit 1 lock error.

## Requirements
- R1: After reset, the command word reads 0x2000_0000 (hold-register select at 1, all else 0). All other registers read 0, and `eng_req`, `irq` and `dma_card_num` are 0.
- R2: With no command pending, a write to any index 0..8 or 10 is read back unchanged on `reg_rdata` in the following cycle.
- R3: One cycle after the start flag (bit 31) becomes set, `eng_req` rises. It stays high until a cycle in which `eng_ack` is 1. At that clock edge, `eng_req` and the start flag both clear.
- R4: While the start flag is set, writes to indices 0..8 are dropped, and raw interrupt bit 1 (lock error) is set.
- R5: A normal launch (bit 21 clear) captures indices 0..5 onto `eng_cmd`..`eng_byte_count`, drives `eng_clk_only` to 0 and leaves the clock outputs unchanged.
- R6: A clock-only launch (bit 21 set) captures only indices 6..8 onto `eng_clk_div`, `eng_clk_src` and `eng_clk_en`. It drives `eng_clk_only` to 1 and leaves the command outputs unchanged.
- R7: An `eng_done` pulse sets raw bit 0 (command done) only if the last acknowledged launch was a normal command that has not yet completed. After a clock-only launch it has no effect.
- R8: Writing 1 to a raw interrupt bit (index 9) clears it. A set event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some raw bit and the matching bit of the mask register (index 10) are both 1.
- R10: `dma_card_num` equals bits 20:16 of the command word as it stood one cycle earlier.
- R11: Writes to indices 9 and 10 are accepted while a command is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| eng_req | output | 1 | Handover request, level |
| eng_ack | input | 1 | One-cycle acknowledge from the engine |
| eng_done | input | 1 | Command sent and response received |
| eng_clk_only | output | 1 | Snapshot is a clock-only update |
| eng_cmd | output | 32 | Captured command word |
| eng_arg | output | 32 | Captured argument |
| eng_timeout | output | 32 | Captured timeout |
| eng_card_type | output | 32 | Captured card type |
| eng_blk_size | output | 32 | Captured block size |
| eng_byte_count | output | 32 | Captured byte count |
| eng_clk_div | output | 32 | Captured clock divider |
| eng_clk_src | output | 32 | Captured clock source |
| eng_clk_en | output | 32 | Captured clock enable |
| dma_card_num | output | 5 | Registered card slot number |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check the following on every cycle: the request holds until acknowledge, the start flag clears at acknowledge, a locked register keeps its value when a write arrives while a command is pending, the snapshot stays stable while the request is up, and command done never rises without a normal command in flight. Only the bench scenarios can show the other behaviours. These are which register subset each kind of launch selects, that a clock-only update raises no completion, the set-over-clear priority, the masking onto `irq`, and the one-cycle lag of the card slot output.

// File: rtl/cmdh_pkg.sv
// Package: shared widths, register indices and command word bit positions
// for the command handoff unit. Assumes a 32-bit word-addressed bus.
package cmdh_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_STORE = 9;              // handed-over registers, indices 0..8
    localparam int IRQ_W     = 2;

    localparam int IDX_CMD    = 0;
    localparam int IDX_ARG    = 1;
    localparam int IDX_TMO    = 2;
    localparam int IDX_CTYPE  = 3;
    localparam int IDX_BLKSZ  = 4;
    localparam int IDX_BYTCNT = 5;
    localparam int IDX_CLKDIV = 6;             // first of the clock group
    localparam int IDX_CLKSRC = 7;
    localparam int IDX_CLKEN  = 8;
    localparam int IDX_RAW    = 9;
    localparam int IDX_MASK   = 10;

    localparam int BIT_START   = 31;
    localparam int BIT_HOLD    = 29;
    localparam int BIT_CLKONLY = 21;
    localparam int CARD_LSB    = 16;
    localparam int CARD_W      = 5;

    localparam int IRQ_DONE = 0;
    localparam int IRQ_LOCK = 1;

    localparam logic [DATA_W-1:0] CMD_RESET = DATA_W'(1) << BIT_HOLD;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/cmdh_regfile.sv
// Module: host-side storage for the nine handed-over registers.
// It refuses writes while the start flag is set and reports each refused
// write. It clears the start flag when the engine acknowledges.
// Assumes the request input comes from cmdh_handoff.
module cmdh_regfile
    import cmdh_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           req_i,
    input  logic                           ack_i,
    output logic [NUM_STORE-1:0][DATA_W-1:0] regs_o,
    output logic                           lock_hit_o
);
    localparam logic [ADDR_W-1:0] LAST_STORE = ADDR_W'(NUM_STORE - 1);

    logic start_q;
    logic store_sel;

    assign start_q    = regs_o[IDX_CMD][BIT_START];
    assign store_sel  = wr_en && (wr_addr <= LAST_STORE);
    assign lock_hit_o = store_sel && start_q;

    // Purpose: register update, reset values, lock and start-flag clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STORE; i++)
                regs_o[i] <= (i == IDX_CMD) ? CMD_RESET : '0;
        end else begin
            if (store_sel && !start_q)
                regs_o[wr_addr] <= wr_data;
            if (req_i && ack_i)
                regs_o[IDX_CMD][BIT_START] <= 1'b0;
        end
    end

    assert_start_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ack_i) |=> !regs_o[IDX_CMD][BIT_START]);

    assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && wr_en && wr_addr == ADDR_W'(IDX_ARG)) |=>
        regs_o[IDX_ARG] == $past(regs_o[IDX_ARG]));
endmodule

// File: rtl/cmdh_handoff.sv
// Module: launches the request when the start flag appears. It captures the
// register subset picked by the clock-only flag and holds the request level
// until a one-cycle acknowledge arrives. Assumes the start flag stays set
// until that acknowledge.
module cmdh_handoff
    import cmdh_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_STORE-1:0][DATA_W-1:0] regs_i,
    input  logic                             ack_i,
    output logic                             req_o,
    output logic                             clk_only_o,
    output logic [NUM_STORE-1:0][DATA_W-1:0] snap_o
);
    logic launch;
    logic sel_clk;

    assign launch  = regs_i[IDX_CMD][BIT_START] && !req_o;
    assign sel_clk = regs_i[IDX_CMD][BIT_CLKONLY];

    // Purpose: request level and launch kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o      <= 1'b0;
            clk_only_o <= 1'b0;
        end else if (req_o && ack_i) begin
            req_o      <= 1'b0;
        end else if (launch) begin
            req_o      <= 1'b1;
            clk_only_o <= sel_clk;
        end
    end

    for (genvar g = 0; g < NUM_STORE; g++) begin : g_snap
        localparam bit IN_CLK_GROUP = (g >= IDX_CLKDIV);
        // Purpose: capture this register only for the matching launch kind.
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap_o[g] <= '0;
            else if (launch && (sel_clk == IN_CLK_GROUP))
                snap_o[g] <= regs_i[g];
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    assert_snap_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && $past(req_o)) |-> ($stable(snap_o[IDX_CMD]) && $stable(snap_o[IDX_CLKDIV])));
endmodule

// File: rtl/cmdh_irq.sv
// Module: raw interrupt bits (write-1-to-clear, set wins), mask register,
// command-in-flight tracking and the combined interrupt line.
// Assumes accept_i is the request-and-acknowledge cycle.
module cmdh_irq
    import cmdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              clk_only_i,
    input  logic              done_i,
    input  logic              lock_hit_i,
    input  logic              raw_wr_i,
    input  logic              mask_wr_i,
    input  logic [IRQ_W-1:0]  wdata_i,
    output logic [IRQ_W-1:0]  raw_o,
    output logic [IRQ_W-1:0]  mask_o,
    output logic              irq_o
);
    logic             inflight_q;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] clr_vec;

    // Purpose: gather the per-bit set events.
    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_DONE] = done_i && inflight_q;
        set_vec[IRQ_LOCK] = lock_hit_i;
    end

    assign clr_vec = raw_wr_i ? wdata_i : '0;

    // Purpose: track a normal command between acknowledge and completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inflight_q <= 1'b0;
        else if (accept_i)
            inflight_q <= !clk_only_i;
        else if (done_i)
            inflight_q <= 1'b0;
    end

    // Purpose: raw bits, a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_o <= '0;
        else
            raw_o <= (raw_o & ~clr_vec) | set_vec;
    end

    // Purpose: mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (mask_wr_i)
            mask_o <= wdata_i;
    end

    assign irq_o = |(raw_o & mask_o);

    assert_done_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o[IRQ_DONE]) |-> $past(inflight_q && done_i));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hit_i |=> raw_o[IRQ_LOCK]);
endmodule

// File: rtl/cmd_handoff_top.sv
// Module: top of the command register handoff unit. It wires storage,
// handoff and interrupt logic, decodes the read mux and registers the card
// slot field. Assumes a single-cycle write strobe and combinational read.
module cmd_handoff_top
    import cmdh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              eng_req,
    input  logic              eng_ack,
    input  logic              eng_done,
    output logic              eng_clk_only,
    output logic [31:0]       eng_cmd,
    output logic [31:0]       eng_arg,
    output logic [31:0]       eng_timeout,
    output logic [31:0]       eng_card_type,
    output logic [31:0]       eng_blk_size,
    output logic [31:0]       eng_byte_count,
    output logic [31:0]       eng_clk_div,
    output logic [31:0]       eng_clk_src,
    output logic [31:0]       eng_clk_en,
    output logic [4:0]        dma_card_num,
    output logic              irq
);
    logic [NUM_STORE-1:0][DATA_W-1:0] regs;
    logic [NUM_STORE-1:0][DATA_W-1:0] snap;
    logic                             lock_hit;
    logic [IRQ_W-1:0]                 raw;
    logic [IRQ_W-1:0]                 mask;
    logic                             raw_wr;
    logic                             mask_wr;

    assign raw_wr  = reg_wr && (reg_addr == ADDR_W'(IDX_RAW));
    assign mask_wr = reg_wr && (reg_addr == ADDR_W'(IDX_MASK));

    cmdh_regfile i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .req_i      (eng_req),
        .ack_i      (eng_ack),
        .regs_o     (regs),
        .lock_hit_o (lock_hit)
    );

    cmdh_handoff i_handoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs_i     (regs),
        .ack_i      (eng_ack),
        .req_o      (eng_req),
        .clk_only_o (eng_clk_only),
        .snap_o     (snap)
    );

    cmdh_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (eng_req && eng_ack),
        .clk_only_i (eng_clk_only),
        .done_i     (eng_done),
        .lock_hit_i (lock_hit),
        .raw_wr_i   (raw_wr),
        .mask_wr_i  (mask_wr),
        .wdata_i    (reg_wdata[IRQ_W-1:0]),
        .raw_o      (raw),
        .mask_o     (mask),
        .irq_o      (irq)
    );

    assign eng_cmd        = snap[IDX_CMD];
    assign eng_arg        = snap[IDX_ARG];
    assign eng_timeout    = snap[IDX_TMO];
    assign eng_card_type  = snap[IDX_CTYPE];
    assign eng_blk_size   = snap[IDX_BLKSZ];
    assign eng_byte_count = snap[IDX_BYTCNT];
    assign eng_clk_div    = snap[IDX_CLKDIV];
    assign eng_clk_src    = snap[IDX_CLKSRC];
    assign eng_clk_en     = snap[IDX_CLKEN];

    // Purpose: read mux over storage, raw and mask.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(NUM_STORE))
            reg_rdata = regs[reg_addr];
        else if (reg_addr == ADDR_W'(IDX_RAW))
            reg_rdata = DATA_W'(raw);
        else if (reg_addr == ADDR_W'(IDX_MASK))
            reg_rdata = DATA_W'(mask);
    end

    // Purpose: registered card slot for DMA request steering.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_card_num <= '0;
        else
            dma_card_num <= regs[IDX_CMD][CARD_LSB +: CARD_W];
    end
endmodule

// File: tb/test_cmd_handoff_top.sv
module test_cmd_handoff_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // vector: {addr[3:0], write data[31:0], expected readback[31:0]}
    localparam logic [67:0] VECS [NVEC] = '{
        {4'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {4'd2,  32'h0000_FFFF, 32'h0000_FFFF},
        {4'd3,  32'h0000_0001, 32'h0000_0001},
        {4'd4,  32'h0000_0200, 32'h0000_0200},
        {4'd5,  32'h0000_1000, 32'h0000_1000},
        {4'd0,  32'h2005_0251, 32'h2005_0251},
        {4'd10, 32'h0000_0002, 32'h0000_0002},
        {4'd12, 32'h1234_5678, 32'h0000_0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, eng_ack = 1'b0, eng_done = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic eng_req, eng_clk_only, irq;
    logic [31:0] eng_cmd, eng_arg, eng_timeout, eng_card_type, eng_blk_size,
                 eng_byte_count, eng_clk_div, eng_clk_src, eng_clk_en;
    logic [4:0] dma_card_num;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_handoff_top i_cmd_handoff_top (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse_ack();
        eng_ack = 1'b1; @(negedge clk); eng_ack = 1'b0;
    endtask

    task automatic pulse_done();
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'd0, v); chk("R1 cmd reset", v, 32'h2000_0000);
        rd(4'd1, v); chk("R1 arg reset", v, 32'h0);
        rd(4'd9, v); chk("R1 raw reset", v, 32'h0);
        chk("R1 req", {31'd0, eng_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 card", {27'd0, dma_card_num}, 32'd0);

        // R2 table-driven readback
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i][67:64], VECS[i][63:32]);
            rd(VECS[i][67:64], v);
            chk("R2 readback", v, VECS[i][31:0]);
        end
        chk("R10 card slot", {27'd0, dma_card_num}, 32'd5);

        // R3/R5 normal launch
        wr(4'd0, 32'h8003_0041);
        chk("R3 req one cycle later", {31'd0, eng_req}, 32'd0);
        @(negedge clk);
        chk("R3 req raised", {31'd0, eng_req}, 32'd1);
        chk("R5 cmd snap", eng_cmd, 32'h8003_0041);
        chk("R5 arg snap", eng_arg, 32'hDEAD_BEEF);
        chk("R5 bytcnt snap", eng_byte_count, 32'h0000_1000);
        chk("R5 clk untouched", eng_clk_div, 32'h0);
        chk("R5 clk_only flag", {31'd0, eng_clk_only}, 32'd0);

        // R4 lock, R11 mask/raw writes accepted, R9 irq, R8 clear
        wr(4'd1, 32'h0BAD_0BAD);
        rd(4'd1, v); chk("R4 arg kept", v, 32'hDEAD_BEEF);
        wr(4'd6, 32'h0000_0077);
        rd(4'd6, v); chk("R4 clkdiv kept", v, 32'h0);
        rd(4'd9, v); chk("R4 lock raw", v, 32'h2);
        chk("R9 irq on masked lock", {31'd0, irq}, 32'd1);
        wr(4'd10, 32'h0000_0001);
        rd(4'd10, v); chk("R11 mask write", v, 32'h1);
        chk("R9 irq masked off", {31'd0, irq}, 32'd0);
        wr(4'd9, 32'h0000_0002);
        rd(4'd9, v); chk("R8 w1c", v, 32'h0);

        repeat (3) @(negedge clk);
        chk("R3 req held", {31'd0, eng_req}, 32'd1);
        pulse_ack();
        chk("R3 req cleared", {31'd0, eng_req}, 32'd0);
        rd(4'd0, v); chk("R3 start cleared", v, 32'h0003_0041);
        @(negedge clk);
        chk("R10 card follows", {27'd0, dma_card_num}, 32'd3);

        // R7 completion for a normal command
        pulse_done();
        rd(4'd9, v); chk("R7 done set", v, 32'h1);
        chk("R9 irq done", {31'd0, irq}, 32'd1);
        wr(4'd9, 32'h1);

        // R6 clock-only launch
        wr(4'd6, 32'h0000_0011);
        wr(4'd7, 32'h0000_0002);
        wr(4'd8, 32'h0000_0001);
        wr(4'd1, 32'h0000_00A2);
        wr(4'd0, 32'h8020_0000);
        @(negedge clk);
        chk("R6 req", {31'd0, eng_req}, 32'd1);
        chk("R6 clkdiv", eng_clk_div, 32'h11);
        chk("R6 clksrc", eng_clk_src, 32'h2);
        chk("R6 clken", eng_clk_en, 32'h1);
        chk("R6 arg untouched", eng_arg, 32'hDEAD_BEEF);
        chk("R6 cmd untouched", eng_cmd, 32'h8003_0041);
        chk("R6 flag", {31'd0, eng_clk_only}, 32'd1);
        pulse_ack();
        pulse_done();
        rd(4'd9, v); chk("R7 no done after clock-only", v, 32'h0);

        // R8 set wins over clear: normal launch, done with same-cycle W1C
        wr(4'd0, 32'h8000_0005);
        @(negedge clk);
        pulse_ack();
        reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 32'h1; eng_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_done = 1'b0;
        rd(4'd9, v); chk("R8 set wins", v, 32'h1);
        chk("R5 arg second launch", eng_arg, 32'h0000_00A2);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule